// File: doc/BRIEF.md
# ADC Sample FIFO with Byte-Wide Host Port

This block buffers 12-bit converter results in a small first-in first-out store and hands them to an 8-bit host bus. The converter side presents samples on a valid/ready stream. The host reads each sample through a single data port as two consecutive byte reads. The first read returns the low eight bits. The second read returns the remaining upper bits, zero-extended, and only that second read removes the sample from the store. A clear strobe empties the store, drops any pending half-read sample and clears the error flags.

The block reports whether data is available and whether the store is below half full. It latches two sticky errors. Overflow is set when a sample arrives with nowhere to go. Overrun is set when the converter starts a new conversion before the previous one has delivered its result. A single interrupt request combines three separately enabled sources: data available, reaching half full, and either error.

The sample stream cannot be held back. `smp_ready` is advisory: it is low while the store is full. A sample offered while `smp_ready` is low is discarded and raises overflow; the converter is not expected to wait.

Top module: `adc_byte_fifo`

## Requirements
- R1: After reset the store is empty: `data_avail`=0, `not_half_full`=1, `overrun`=0, `overflow`=0, `irq`=0, `smp_ready`=1, and the next host read is a low byte.
- R2: Samples leave in arrival order. With `data_avail`=1, `rd_byte` shows bits 7:0 of the oldest sample. After one `bus_rd` it shows bits 11:8 in its low nibble, with the upper nibble zero. The sample is removed only by that second `bus_rd`.
- R3: A sample offered (`smp_valid`=1) while the store holds DEPTH samples is discarded and sets `overflow`; the stored samples are unchanged.
- R4: A `conv_start` pulse while an earlier conversion has not yet delivered its sample (no `smp_valid` since that start, and none in the same cycle) sets `overrun`. Both error flags are sticky until a clear.
- R5: A `clr_wr` pulse empties the store, clears `overrun` and `overflow`, and returns the byte phase to low. A clear takes priority over a sample or read in the same cycle.
- R6: `data_avail` is 1 exactly when at least one sample is stored.
- R7: `not_half_full` is 0 exactly when the store holds DEPTH/2 or more samples.
- R8: With `en_ne_irq`=1, `irq` is 1 whenever `data_avail` is 1.
- R9: With `en_hf_irq`=1, `irq` is 1 whenever `not_half_full` is 0.
- R10: With `en_err_irq`=1, `irq` is 1 whenever `overrun` or `overflow` is set. With all three enables at 0, `irq` is 0.
- R11: A `bus_rd` while the store is empty returns 0 and changes nothing: the byte phase stays low and no sample is lost.
- R12: `smp_ready` is 0 exactly when the store holds DEPTH samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Converter presents a sample |
| smp_data | input | 12 | Conversion result |
| smp_ready | output | 1 | Store has room (advisory) |
| conv_start | input | 1 | Pulse: a conversion has begun |
| bus_rd | input | 1 | Host read strobe on the data port |
| rd_byte | output | 8 | Byte returned by the data port |
| clr_wr | input | 1 | Host write strobe on the clear port |
| en_ne_irq | input | 1 | Enable interrupt on data available |
| en_hf_irq | input | 1 | Enable interrupt on half full |
| en_err_irq | input | 1 | Enable interrupt on overrun or overflow |
| data_avail | output | 1 | At least one sample stored |
| not_half_full | output | 1 | Fewer than DEPTH/2 samples stored |
| overrun | output | 1 | Sticky overrun error |
| overflow | output | 1 | Sticky overflow error |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench fills the store to exactly DEPTH and then offers one more sample. A design that overwrote the oldest entry, or that let the extra sample wrap the write pointer, would return a wrong sequence on readback. It clears the store midway through a two-byte read. A design that kept the byte phase would return a high nibble where a low byte belongs. It reads an empty store and then checks that the next real sample still starts at its low byte; a design that toggled the phase on an empty read fails that check. It starts two conversions back to back with and without a result in between, and checks the half-full boundary from both sides, because an off-by-one threshold shifts both `not_half_full` and the half-full interrupt.

// File: rtl/adcf_pkg.sv
package adcf_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } byte_phase_e;
endpackage

// File: rtl/adcf_sample_store.sv
module adcf_sample_store #(
  parameter int DEPTH = 16,
  parameter int SW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [SW-1:0] push_data,
  input  logic          pop,
  input  logic          clear,
  output logic [SW-1:0] head,
  output logic          empty,
  output logic          full,
  output logic          at_half
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head    = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign at_half = (count >= CW'(DEPTH / 2));
endmodule

// File: rtl/adcf_byte_reader.sv
module adcf_byte_reader
  import adcf_pkg::*;
#(
  parameter int SW = 12,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          avail,
  input  logic          clear,
  input  logic [SW-1:0] head,
  output logic [BW-1:0] rd_byte,
  output logic          pop
);
  byte_phase_e phase;
  logic        step;

  assign step = bus_rd && avail;
  assign pop  = step && (phase == PH_HIGH);

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  phase <= PH_LOW;
    else if (step)        phase <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
  end

  always_comb begin
    if (!avail)               rd_byte = '0;
    else if (phase == PH_LOW) rd_byte = head[BW-1:0];
    else                      rd_byte = BW'(head[SW-1:BW]);
  end
endmodule

// File: rtl/adcf_err_tracker.sv
module adcf_err_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_start,
  input  logic smp_valid,
  input  logic drop,
  input  logic clear,
  output logic overrun,
  output logic overflow
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      overrun  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      pending <= conv_start || (pending && !smp_valid);
      if (clear) begin
        overrun  <= 1'b0;
        overflow <= 1'b0;
      end else begin
        if (conv_start && pending && !smp_valid) overrun <= 1'b1;
        if (drop) overflow <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_byte_fifo.sv
module adc_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int SW    = 12,
  parameter int BW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  output logic          smp_ready,
  input  logic          conv_start,
  input  logic          bus_rd,
  output logic [BW-1:0] rd_byte,
  input  logic          clr_wr,
  input  logic          en_ne_irq,
  input  logic          en_hf_irq,
  input  logic          en_err_irq,
  output logic          data_avail,
  output logic          not_half_full,
  output logic          overrun,
  output logic          overflow,
  output logic          irq
);
  logic          empty, full, at_half, push, pop, drop;
  logic [SW-1:0] head;

  assign push = smp_valid && !full && !clr_wr;
  assign drop = smp_valid && full && !clr_wr;

  adcf_sample_store #(.DEPTH(DEPTH), .SW(SW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(smp_data),
    .pop(pop), .clear(clr_wr), .head(head), .empty(empty),
    .full(full), .at_half(at_half)
  );

  adcf_byte_reader #(.SW(SW), .BW(BW)) u_reader (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .avail(!empty),
    .clear(clr_wr), .head(head), .rd_byte(rd_byte), .pop(pop)
  );

  adcf_err_tracker u_err (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .smp_valid(smp_valid),
    .drop(drop), .clear(clr_wr), .overrun(overrun), .overflow(overflow)
  );

  assign smp_ready     = !full;
  assign data_avail    = !empty;
  assign not_half_full = !at_half;
  assign irq = (en_ne_irq && data_avail) || (en_hf_irq && at_half) ||
               (en_err_irq && (overrun || overflow));
endmodule

// File: rtl/adc_byte_fifo_chk.sv
module adc_byte_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_valid,
  input logic smp_ready,
  input logic clr_wr,
  input logic en_ne_irq,
  input logic en_hf_irq,
  input logic data_avail,
  input logic not_half_full,
  input logic overrun,
  input logic overflow,
  input logic irq
);
  p_drop_sets_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && !clr_wr) |=> overflow);

  p_overrun_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_wr) |=> overrun);

  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (!data_avail && !overflow && !overrun));

  p_half_implies_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !not_half_full |-> data_avail);

  p_irq_ne_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_ne_irq && data_avail) |-> irq);

  p_irq_hf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_hf_irq && !not_half_full) |-> irq);

  p_ready_when_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !data_avail |-> smp_ready);
endmodule

bind adc_byte_fifo adc_byte_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .clr_wr(clr_wr), .en_ne_irq(en_ne_irq), .en_hf_irq(en_hf_irq),
  .data_avail(data_avail), .not_half_full(not_half_full),
  .overrun(overrun), .overflow(overflow), .irq(irq)
);

// File: tb/tb_adc_byte_fifo.sv
module tb_adc_byte_fifo;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic smp_ready, conv_start = 1'b0, bus_rd = 1'b0, clr_wr = 1'b0;
  logic [7:0] rd_byte;
  logic en_ne_irq = 1'b0, en_hf_irq = 1'b0, en_err_irq = 1'b0;
  logic data_avail, not_half_full, overrun, overflow, irq;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  adc_byte_fifo #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_ready(smp_ready), .conv_start(conv_start), .bus_rd(bus_rd),
    .rd_byte(rd_byte), .clr_wr(clr_wr), .en_ne_irq(en_ne_irq),
    .en_hf_irq(en_hf_irq), .en_err_irq(en_err_irq), .data_avail(data_avail),
    .not_half_full(not_half_full), .overrun(overrun), .overflow(overflow),
    .irq(irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    smp_valid = 1'b0; conv_start = 1'b0; bus_rd = 1'b0; clr_wr = 1'b0;
  endtask

  task automatic push(input logic [11:0] d);
    smp_valid = 1'b1; smp_data = d; tick();
  endtask

  task automatic read_byte(output logic [7:0] b);
    b = rd_byte; bus_rd = 1'b1; tick();
  endtask

  task automatic clear();
    clr_wr = 1'b1; tick();
  endtask

  task automatic t_reset();
    check(!data_avail, "R1 avail", data_avail, 0);
    check(not_half_full, "R1 nhf", not_half_full, 1);
    check(!overrun && !overflow, "R1 errs", {overrun, overflow}, 0);
    check(!irq && smp_ready, "R1 irq/ready", {irq, smp_ready}, 1);
  endtask

  task automatic t_order();
    logic [7:0] b;
    push(12'hA5C); push(12'h3F1); push(12'h807);
    check(data_avail, "R6 avail", data_avail, 1);
    read_byte(b); check(b == 8'h5C, "R2 lo0", b, 8'h5C);
    check(data_avail, "R2 no pop after low", data_avail, 1);
    read_byte(b); check(b == 8'h0A, "R2 hi0", b, 8'h0A);
    read_byte(b); check(b == 8'hF1, "R2 lo1", b, 8'hF1);
    read_byte(b); check(b == 8'h03, "R2 hi1", b, 8'h03);
    read_byte(b); check(b == 8'h07, "R2 lo2", b, 8'h07);
    read_byte(b); check(b == 8'h08, "R2 hi2", b, 8'h08);
    check(!data_avail, "R6 empty after drain", data_avail, 0);
  endtask

  task automatic t_fill_overflow();
    logic [7:0] lo, hi;
    clear();
    for (int k = 0; k < DEPTH; k++) begin
      if (k == DEPTH / 2 - 1) check(not_half_full, "R7 below half", not_half_full, 1);
      if (k == DEPTH / 2)     check(!not_half_full, "R7 at half", not_half_full, 0);
      push(12'(k * 37 + 5));
    end
    check(!smp_ready, "R12 ready low when full", smp_ready, 0);
    check(!overflow, "R3 no overflow yet", overflow, 0);
    push(12'hFFF);
    check(overflow, "R3 overflow set", overflow, 1);
    for (int k = 0; k < DEPTH; k++) begin
      read_byte(lo); read_byte(hi);
      check({hi[3:0], lo} == 12'(k * 37 + 5) && hi[7:4] == 4'h0, "R3 contents kept",
            {hi, lo}, 12'(k * 37 + 5));
    end
    check(!data_avail && smp_ready, "R12 ready after drain", {data_avail, smp_ready}, 1);
    check(overflow, "R4 overflow sticky", overflow, 1);
    clear();
    check(!overflow, "R5 overflow cleared", overflow, 0);
  endtask

  task automatic t_clear_phase();
    logic [7:0] b;
    push(12'h123); push(12'h456);
    read_byte(b);
    clear();
    check(!data_avail, "R5 emptied", data_avail, 0);
    push(12'hABC);
    read_byte(b); check(b == 8'hBC, "R5 phase back to low", b, 8'hBC);
    read_byte(b); check(b == 8'h0A, "R5 high after clear", b, 8'h0A);
  endtask

  task automatic t_empty_read();
    logic [7:0] b;
    clear();
    read_byte(b); check(b == 8'h00, "R11 empty read zero", b, 0);
    push(12'h9E4);
    read_byte(b); check(b == 8'hE4, "R11 phase untouched", b, 8'hE4);
    read_byte(b); check(b == 8'h09, "R11 sample intact", b, 8'h09);
  endtask

  task automatic t_overrun();
    clear();
    conv_start = 1'b1; tick();
    push(12'h001);
    conv_start = 1'b1; tick();
    check(!overrun, "R4 no overrun with result", overrun, 0);
    conv_start = 1'b1; tick();
    check(overrun, "R4 overrun set", overrun, 1);
    tick();
    check(overrun, "R4 overrun sticky", overrun, 1);
    check(!irq, "R10 irq off when disabled", irq, 0);
    en_err_irq = 1'b1; #1;
    check(irq, "R10 error irq", irq, 1);
    en_err_irq = 1'b0;
    clear();
    check(!overrun, "R5 overrun cleared", overrun, 0);
  endtask

  task automatic t_irq();
    clear();
    en_ne_irq = 1'b1; #1;
    check(!irq, "R8 no irq empty", irq, 0);
    push(12'h111);
    check(irq, "R8 ne irq", irq, 1);
    en_ne_irq = 1'b0; en_hf_irq = 1'b1; #1;
    check(!irq, "R9 below half no irq", irq, 0);
    for (int k = 1; k < DEPTH / 2; k++) push(12'(k));
    check(irq, "R9 hf irq", irq, 1);
    en_hf_irq = 1'b0; #1;
    check(!irq, "R10 all disabled", irq, 0);
    clear();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_fill_overflow();
    t_clear_phase();
    t_empty_read();
    t_overrun();
    t_irq();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule